// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps track of which of 256 interrupt vectors are waiting for service and which are being serviced. It also records whether each vector was signalled by level or by edge. Three 256-bit bitmaps hold this state: request, in-service and trigger. An 8-bit task priority, written by software, is combined with the highest in-service vector to form a processor priority. Only the upper nibble of a vector, its priority class, decides whether the highest request may interrupt.

A source presents a vector on the accept port and receives a one-cycle answer: either the request was newly recorded, or it was discarded. The core sees `irq_pending` and `irq_vec`, and takes the offered vector by pulsing `ack_in`. It ends service with `eoi_in`, and the block then reports the retired vector and whether it was level-triggered. All results are registered, so every output reflects the state after the previous clock edge.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, all three bitmaps and the task priority are zero. `ppr` is 0, `irq_pending` is 0, and `acc_resp_valid` and `eoi_valid` are 0.
- R2: `ppr` equals the task priority when task priority bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise `ppr` is that vector with bits [3:0] cleared. An empty in-service set counts as vector 0.
- R3: `irq_pending` is 1 exactly when a request bit is set and the highest set request vector, with bits [3:0] cleared, is strictly greater than `ppr`. `irq_vec` then carries that highest request vector.
- R4: `ack_in` while `irq_pending` is 1 sets the in-service bit of `irq_vec` and clears its request bit. `ack_in` while `irq_pending` is 0 has no effect.
- R5: `eoi_in` clears the highest set in-service bit and the trigger bit of that vector. One cycle later `eoi_valid` is 1, `eoi_vec` holds the vector, and `eoi_level` holds the old trigger bit (1 = level, 0 = edge). With no in-service bit set, `eoi_in` does nothing and `eoi_valid` stays 0.
- R6: An enabled accept sets the request bit and writes `acc_level` into the trigger bit. If the request bit was already set and `acc_level` is 1, the event is dropped and the trigger bit is left unchanged. An edge duplicate rewrites the trigger bit to 0.
- R7: Accepts take effect only while both `hw_en` and `sw_en` are 1. `sw_en` is bit 8 of the spurious-vector configuration. A disabled accept changes no state.
- R8: One cycle after every `acc_valid`, `acc_resp_valid` is 1. `acc_resp_new` is 1 only if a request bit that was clear got set.
- R9: Outputs are registered. Each change in `ppr`, `irq_pending`, `irq_vec` and the response strobes appears in the cycle after the input that caused it.
- R10: When several events fall in the same cycle, they apply in this order: end of interrupt (using the trigger bit from before the cycle), then accept, then acknowledge, then the task-priority write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable (bit 8 of spurious-vector configuration) |
| acc_valid | input | 1 | Accept strobe |
| acc_vec | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge |
| acc_resp_valid | output | 1 | Accept answer strobe |
| acc_resp_new | output | 1 | 1 = request newly recorded |
| irq_pending | output | 1 | A deliverable vector is offered |
| irq_vec | output | 8 | Offered vector |
| ack_in | input | 1 | Core takes the offered vector |
| eoi_in | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | A vector was retired |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority value |
| ppr | output | 8 | Processor priority |

## Verification
The assertions check on every cycle the rules that depend only on the current state:
- `ppr` never falls below the task priority.
- An offered vector's class is always above `ppr`.
- An acknowledge moves the offered vector from request to in-service.
- An end of interrupt with an empty in-service set stays silent.
- A disabled accept is never reported as new.
- Every accept is answered exactly one cycle later.

Other behaviours need the bench's scenarios and its reference model:
- the exact `ppr` value against the class boundaries;
- the strict comparison at equal class;
- trigger bits surviving a dropped level duplicate and being rewritten by an edge duplicate;
- the retired trigger mode;
- the same-cycle ordering of end of interrupt, accept and acknowledge.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    localparam int VPC_NVEC     = 256;
    localparam int VPC_CLS_BITS = 4;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Ascending scan: the last set bit seen is the highest one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vpc_prio_gate.sv
module vpc_prio_gate #(
    parameter int VW       = 8,
    parameter int CLS_BITS = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_found,
    input  logic [VW-1:0] isr_hi,
    input  logic          irr_found,
    input  logic [VW-1:0] irr_hi,
    output logic [VW-1:0] ppr,
    output logic          deliver
);
    localparam int LSB = VW - CLS_BITS;
    localparam logic [VW-1:0] CMASK = ~(VW'((1 << LSB) - 1));

    logic [VW-1:0] isr_eff;

    always_comb begin
        isr_eff = isr_found ? isr_hi : '0;
        if (tpr[VW-1:LSB] >= isr_eff[VW-1:LSB]) begin
            ppr = tpr;
        end else begin
            ppr = isr_eff & CMASK;
        end
        deliver = irr_found && ((irr_hi & CMASK) > ppr);
    end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
    import vpc_pkg::*;
#(
    parameter int NVEC     = VPC_NVEC,
    parameter int CLS_BITS = VPC_CLS_BITS,
    localparam int VW      = $clog2(NVEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_en,
    input  logic          sw_en,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vec,
    input  logic          acc_level,
    output logic          acc_resp_valid,
    output logic          acc_resp_new,
    output logic          irq_pending,
    output logic [VW-1:0] irq_vec,
    input  logic          ack_in,
    input  logic          eoi_in,
    output logic          eoi_valid,
    output logic [VW-1:0] eoi_vec,
    output logic          eoi_level,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    output logic [VW-1:0] ppr
);
    typedef struct packed {
        logic [NVEC-1:0] irr;
        logic [NVEC-1:0] isr;
        logic [NVEC-1:0] tmr;
        logic [VW-1:0]   tpr;
        logic            rsp_vld;
        logic            rsp_new;
        logic            eoi_vld;
        logic [VW-1:0]   eoi_vec;
        trig_e           eoi_trig;
    } core_t;

    typedef struct packed {
        logic          isr_vld;
        logic [VW-1:0] isr_hi;
        logic [VW-1:0] ppr;
        logic          pend;
        logic [VW-1:0] vec;
    } view_t;

    core_t c_d, c_q;
    view_t v_d, v_q;

    logic          acc_en;
    logic          hi_isr_found, hi_irr_found, deliver_d;
    logic [VW-1:0] hi_isr_idx, hi_irr_idx, ppr_d;

    assign acc_en = acc_valid && hw_en && sw_en;

    // State update order: end of interrupt, accept, acknowledge, priority write.
    always_comb begin
        c_d          = c_q;
        c_d.rsp_vld  = acc_valid;
        c_d.rsp_new  = 1'b0;
        c_d.eoi_vld  = 1'b0;
        c_d.eoi_vec  = '0;
        c_d.eoi_trig = TRIG_EDGE;
        if (eoi_in && v_q.isr_vld) begin
            c_d.eoi_vld              = 1'b1;
            c_d.eoi_vec              = v_q.isr_hi;
            c_d.eoi_trig             = trig_e'(c_q.tmr[v_q.isr_hi]);
            c_d.isr[v_q.isr_hi]      = 1'b0;
            c_d.tmr[v_q.isr_hi]      = 1'b0;
        end
        if (acc_en && !(c_q.irr[acc_vec] && acc_level)) begin
            c_d.rsp_new          = !c_q.irr[acc_vec];
            c_d.irr[acc_vec]     = 1'b1;
            c_d.tmr[acc_vec]     = acc_level;
        end
        if (ack_in && v_q.pend) begin
            c_d.isr[v_q.vec] = 1'b1;
            c_d.irr[v_q.vec] = 1'b0;
        end
        if (tpr_we) begin
            c_d.tpr = tpr_wdata;
        end
    end

    vpc_msb_find #(.W(NVEC), .IW(VW)) u_hi_isr (
        .bits  (c_d.isr),
        .found (hi_isr_found),
        .idx   (hi_isr_idx)
    );

    vpc_msb_find #(.W(NVEC), .IW(VW)) u_hi_irr (
        .bits  (c_d.irr),
        .found (hi_irr_found),
        .idx   (hi_irr_idx)
    );

    vpc_prio_gate #(.VW(VW), .CLS_BITS(CLS_BITS)) u_gate (
        .tpr       (c_d.tpr),
        .isr_found (hi_isr_found),
        .isr_hi    (hi_isr_idx),
        .irr_found (hi_irr_found),
        .irr_hi    (hi_irr_idx),
        .ppr       (ppr_d),
        .deliver   (deliver_d)
    );

    always_comb begin
        v_d.isr_vld = hi_isr_found;
        v_d.isr_hi  = hi_isr_idx;
        v_d.ppr     = ppr_d;
        v_d.pend    = deliver_d;
        v_d.vec     = hi_irr_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            v_q <= '0;
        end else begin
            c_q <= c_d;
            v_q <= v_d;
        end
    end

    assign acc_resp_valid = c_q.rsp_vld;
    assign acc_resp_new   = c_q.rsp_new;
    assign eoi_valid      = c_q.eoi_vld;
    assign eoi_vec        = c_q.eoi_vec;
    assign eoi_level      = (c_q.eoi_trig == TRIG_LEVEL);
    assign irq_pending    = v_q.pend;
    assign irq_vec        = v_q.vec;
    assign ppr            = v_q.ppr;
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
    parameter int NVEC     = 256,
    parameter int CLS_BITS = 4,
    parameter int VW       = $clog2(NVEC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            hw_en,
    input logic            sw_en,
    input logic            ack_in,
    input logic            eoi_in,
    input logic            irq_pending,
    input logic [VW-1:0]   irq_vec,
    input logic [VW-1:0]   ppr,
    input logic [VW-1:0]   tpr,
    input logic [NVEC-1:0] irr_q,
    input logic [NVEC-1:0] isr_q,
    input logic            eoi_valid,
    input logic            acc_resp_valid,
    input logic            acc_resp_new
);
    localparam logic [VW-1:0] CMASK = ~(VW'((1 << (VW - CLS_BITS)) - 1));

    a_r2_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr);

    a_r3_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ((irq_vec & CMASK) > ppr));

    a_r4_ack_to_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && irq_pending) |=> isr_q[$past(irq_vec)]);

    a_r4_ack_clr_irr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && irq_pending) |=> !irr_q[$past(irq_vec)]);

    a_r5_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_in && (isr_q == '0)) |=> !eoi_valid);

    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(hw_en && sw_en)) |=> !acc_resp_new);

    a_r8_resp: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> acc_resp_valid);

    a_r8_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !acc_resp_valid);
endmodule

bind vec_prio_ctrl vpc_chk #(.NVEC(NVEC), .CLS_BITS(CLS_BITS), .VW(VW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .hw_en          (hw_en),
    .sw_en          (sw_en),
    .ack_in         (ack_in),
    .eoi_in         (eoi_in),
    .irq_pending    (irq_pending),
    .irq_vec        (irq_vec),
    .ppr            (ppr),
    .tpr            (c_q.tpr),
    .irr_q          (c_q.irr),
    .isr_q          (c_q.isr),
    .eoi_valid      (eoi_valid),
    .acc_resp_valid (acc_resp_valid),
    .acc_resp_new   (acc_resp_new)
);

// File: tb/test_vec_prio_ctrl.sv
module test_vec_prio_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1, sw_en = 1'b1;
    logic       acc_valid = 1'b0, acc_level = 1'b0;
    logic [7:0] acc_vec = '0;
    logic       ack_in = 1'b0, eoi_in = 1'b0, tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       acc_resp_valid, acc_resp_new, irq_pending, eoi_valid, eoi_level;
    logic [7:0] irq_vec, eoi_vec, ppr;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    int m_tpr = 0;
    int e_ppr = 0, e_pend = 0, e_vec = 0;
    int e_rv = 0, e_rn = 0, e_ev = 0, e_evec = 0, e_elvl = 0;

    always #(CLK_P/2) clk = ~clk;

    vec_prio_ctrl i_vec_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .acc_resp_valid(acc_resp_valid), .acc_resp_new(acc_resp_new),
        .irq_pending(irq_pending), .irq_vec(irq_vec), .ack_in(ack_in),
        .eoi_in(eoi_in), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .eoi_level(eoi_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr(ppr)
    );

    function automatic int hi(logic [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic recompute();
        int hs, hr;
        hs = hi(m_isr);
        if (hs < 0) hs = 0;
        if ((m_tpr >> 4) >= (hs >> 4)) e_ppr = m_tpr;
        else e_ppr = hs & 'hF0;
        hr = hi(m_irr);
        e_pend = (hr >= 0 && (hr & 'hF0) > e_ppr) ? 1 : 0;
        e_vec = hr;
    endtask

    // R9: every step compares all outputs one clock after the inputs are applied
    task automatic step(int av, int vec, int lvl, int ak, int eo, int tw, int tv);
        int h;
        @(negedge clk);
        acc_valid = av[0]; acc_vec = vec[7:0]; acc_level = lvl[0];
        ack_in = ak[0]; eoi_in = eo[0]; tpr_we = tw[0]; tpr_wdata = tv[7:0];
        // R10 ordering: eoi, accept, ack, tpr write
        e_ev = 0; e_evec = 0; e_elvl = 0;
        if (eo != 0) begin
            h = hi(m_isr);
            if (h >= 0) begin
                e_ev = 1; e_evec = h; e_elvl = m_tmr[h];
                m_isr[h] = 1'b0; m_tmr[h] = 1'b0;
            end
        end
        e_rv = av; e_rn = 0;
        if (av != 0 && hw_en && sw_en && !(m_irr[vec] && lvl != 0)) begin
            e_rn = m_irr[vec] ? 0 : 1;
            m_irr[vec] = 1'b1;
            m_tmr[vec] = lvl[0];
        end
        if (ak != 0 && e_pend != 0) begin
            m_isr[e_vec] = 1'b1;
            m_irr[e_vec] = 1'b0;
        end
        if (tw != 0) m_tpr = tv & 'hFF;
        recompute();
        @(posedge clk);
        #1;
        cmp("R2 ppr", ppr, e_ppr);
        cmp("R3 irq_pending", irq_pending, e_pend);
        if (e_pend != 0) cmp("R3 irq_vec", irq_vec, e_vec);
        cmp("R8 acc_resp_valid", acc_resp_valid, e_rv);
        cmp("R8 acc_resp_new", acc_resp_new, e_rn);
        cmp("R5 eoi_valid", eoi_valid, e_ev);
        if (e_ev != 0) begin
            cmp("R5 eoi_vec", eoi_vec, e_evec);
            cmp("R5 eoi_level", eoi_level, e_elvl);
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL R9 watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        recompute();
        idle();
        // R1 reset state
        cmp("R1 ppr", ppr, 0);
        cmp("R1 irq_pending", irq_pending, 0);
        cmp("R1 eoi_valid", eoi_valid, 0);
        cmp("R1 acc_resp_valid", acc_resp_valid, 0);

        step(1, 'h35, 0, 0, 0, 0, 0);
        cmp("R6 new edge", acc_resp_new, 1);
        cmp("R3 vec 0x35", irq_vec, 'h35);
        step(1, 'h80, 1, 0, 0, 0, 0);
        cmp("R3 vec 0x80", irq_vec, 'h80);
        step(1, 'h80, 1, 0, 0, 0, 0);
        cmp("R6 level dup dropped", acc_resp_new, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        cmp("R4 ppr after ack", ppr, 'h80);
        cmp("R4 nothing above", irq_pending, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        cmp("R5 eoi vec", eoi_vec, 'h80);
        cmp("R6 level bit kept", eoi_level, 1);
        cmp("R5 ppr back", ppr, 0);
        step(0, 0, 0, 0, 0, 1, 'h40);
        cmp("R2 tpr 0x40", ppr, 'h40);
        cmp("R3 masked by tpr", irq_pending, 0);
        step(0, 0, 0, 0, 0, 1, 'h2A);
        cmp("R2 tpr 0x2A", ppr, 'h2A);
        cmp("R3 unmasked", irq_pending, 1);
        step(1, 'h3F, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        cmp("R2 isr class wins", ppr, 'h30);
        cmp("R3 equal class blocked", irq_pending, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        cmp("R5 edge retire", eoi_level, 0);
        step(1, 'h35, 0, 0, 0, 0, 0);
        cmp("R6 edge dup not new", acc_resp_new, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        cmp("R5 empty eoi silent", eoi_valid, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        cmp("R4 ack without pending", ppr, 'h2A);

        hw_en = 1'b0;
        step(1, 'h90, 0, 0, 0, 0, 0);
        cmp("R7 hw disabled", acc_resp_new, 0);
        cmp("R7 hw no pend", irq_pending, 0);
        hw_en = 1'b1; sw_en = 1'b0;
        step(1, 'h91, 0, 0, 0, 0, 0);
        cmp("R7 sw disabled", irq_pending, 0);
        sw_en = 1'b1;

        step(0, 0, 0, 0, 0, 1, 0);
        step(1, 'h0F, 0, 0, 0, 0, 0);
        cmp("R3 class 0 never", irq_pending, 0);
        step(1, 'hFF, 0, 0, 0, 0, 0);
        cmp("R3 top vector", irq_vec, 'hFF);
        step(0, 0, 0, 1, 0, 0, 0);
        cmp("R2 ppr F0", ppr, 'hF0);
        step(1, 'hFF, 1, 1, 1, 0, 0);
        cmp("R10 eoi then accept", irq_vec, 'hFF);
        cmp("R10 accept new", acc_resp_new, 1);
        step(1, 'h50, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        cmp("R10 trigger from accept", eoi_level, 1);

        for (int k = 0; k < 3000; k++) begin
            int v;
            v = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                            : 16 * int'($urandom_range(0, 15)) + int'($urandom_range(0, 2));
            if ($urandom_range(0, 63) == 0) hw_en = ~hw_en;
            if ($urandom_range(0, 63) == 0) sw_en = ~sw_en;
            step(($urandom_range(0, 1) == 0) ? 1 : 0, v, int'($urandom_range(0, 1)),
                 ($urandom_range(0, 2) == 0) ? 1 : 0, ($urandom_range(0, 3) == 0) ? 1 : 0,
                 ($urandom_range(0, 15) == 0) ? 1 : 0, int'($urandom_range(0, 255)));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule